// File: doc/BRIEF.md
# Two-Channel PWM Compare and Action Output Stage

This stage sits behind a time-base counter and turns its count into two PWM waveforms. Each cycle it receives the counter value, a strobe marking the count at zero, a strobe marking the count at its period value, a flag saying the counter advanced on this tick, and the counting direction. Two compare registers are matched against the count. A match counts as an event only on a tick where the counter advances while counting up.

Each output has its own action table. For each of three events (counter at zero, compare-A match while rising, compare-B match while rising), the table says whether to leave the output alone, drive it low, drive it high or toggle it. Each compare register can be written directly, or it can be written through a shadow copy that becomes active at a selectable counter event. A per-channel force code can pin either output high or low for as long as the code is set. Configuration arrives on a simple single-cycle write port.

Top module: `pwm_aq_stage`

## Requirements
- R1: After reset both outputs are low, both compare values are 0, both compare registers are in direct-write mode, every action entry is "no action" and no force is active, so a full counter period leaves both outputs low.
- R2: Write-port addresses are: 0 compare A, 1 compare B, 2 compare control, 3 output-A action table, 4 output-B action table, 5 force register. Writes take one cycle with `wr_en` high.
- R3: In direct mode (shadow bit 0), a compare write becomes the active compare value on the next cycle.
- R4: Compare control uses bit 0 as the shadow enable for A and bit 1 as the shadow enable for B. Bits [3:2] select the load point for A and bits [5:4] the load point for B: 0 loads on the zero strobe, 1 on the period strobe, 2 on either strobe, 3 never. In shadow mode a write goes only to the shadow copy, and the active value changes only at the selected point.
- R5: A compare event fires only on a tick with `cnt_adv` high, `cnt_up` high and `cnt_val` equal to the active compare value. Counting down, or holding the count, produces no compare event.
- R6: Each action field is 2 bits: 0 no action, 1 drive low, 2 drive high, 3 toggle. An action table word holds the zero action in [1:0], the compare-A action in [3:2] and the compare-B action in [5:4].
- R7: Output B follows its own table independently of output A. With zero set to high and compare-B set to low, it gives a high time of `cmp_b` ticks per period.
- R8: When several events with actions other than "no action" fall on one tick, compare-B wins over compare-A, and compare-A wins over zero.
- R9: The force register holds a 2-bit code per channel at bit offset 2×channel (A at [1:0], B at [3:2]): 1 forces low, 2 forces high, and 0 or 3 leaves the action table in control. A forced level shows on the output one cycle after the code is in place and overrides every event.
- R10: After a force is cleared, the output keeps the forced level until the next event whose action is not "no action".
- R11: With zero set to high and compare-A set to low on an up counter of period P, a compare value N gives a high time of min(N, P+1) ticks per period. N = 0 gives zero duty. Inverting the two actions gives a low time of the same length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | CW | Current time-base count |
| cnt_zero | input | 1 | Count is at zero on this tick |
| cnt_prd | input | 1 | Count is at the period value on this tick |
| cnt_adv | input | 1 | Counter advanced on this tick |
| cnt_up | input | 1 | Counter direction, 1 = up |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | AW | Configuration register address |
| wr_data | input | CW | Configuration write data |
| pwm_a | output | 1 | Registered PWM output A |
| pwm_b | output | 1 | Registered PWM output B |

## Verification
The hardest case to reach is a shadowed compare whose new value must stay invisible while the old one is still matching in the same counter period. The bench drives the counter itself, so it can stop the count part-way through a period, rewrite the control and compare registers while the counter holds, and then resume. It counts high ticks over the rest of that period and over the next full period, which separates old and new active values for each load point. The same pause-and-resume method places a force release between events to show that the output holds its level until the next event.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_LOW  = 2'd1,
    ACT_HIGH = 2'd2,
    ACT_TOG  = 2'd3
  } aq_act_e;

  typedef enum logic [1:0] {
    LD_ZERO = 2'd0,
    LD_PRD  = 2'd1,
    LD_BOTH = 2'd2,
    LD_HOLD = 2'd3
  } ld_sel_e;

  typedef struct packed {
    aq_act_e on_cb;
    aq_act_e on_ca;
    aq_act_e on_zro;
  } act_cfg_t;

  localparam int unsigned NCH = 2;

  localparam logic [2:0] ADDR_CMP_A = 3'd0;
  localparam logic [2:0] ADDR_CMP_B = 3'd1;
  localparam logic [2:0] ADDR_CTRL  = 3'd2;
  localparam logic [2:0] ADDR_ACT_A = 3'd3;
  localparam logic [2:0] ADDR_ACT_B = 3'd4;
  localparam logic [2:0] ADDR_FRC   = 3'd5;

  localparam logic [1:0] FRC_LOW  = 2'd1;
  localparam logic [1:0] FRC_HIGH = 2'd2;

endpackage

// File: rtl/aq_cfg_regs.sv
module aq_cfg_regs
  import pwm_aq_pkg::*;
#(
  parameter int CW = 16,
  parameter int AW = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [AW-1:0]                 wr_addr,
  input  logic [CW-1:0]                 wr_data,
  output logic [NCH-1:0]                cmp_wr,
  output logic [NCH-1:0]                shadow_en,
  output ld_sel_e [NCH-1:0]             ld_sel,
  output act_cfg_t [NCH-1:0]            act_cfg,
  output logic [NCH-1:0][1:0]           frc_code
);

  localparam int ACT_W = $bits(act_cfg_t);

  logic [5:0]           ctrl_q;
  act_cfg_t [NCH-1:0]   act_q;
  logic [2*NCH-1:0]     frc_q;

  // Compare data travels straight through; only the strobe is decoded here.
  always_comb begin
    cmp_wr[0] = wr_en && (wr_addr == AW'(ADDR_CMP_A));
    cmp_wr[1] = wr_en && (wr_addr == AW'(ADDR_CMP_B));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      act_q  <= '0;
      frc_q  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        AW'(ADDR_CTRL):  ctrl_q   <= wr_data[5:0];
        AW'(ADDR_ACT_A): act_q[0] <= act_cfg_t'(wr_data[ACT_W-1:0]);
        AW'(ADDR_ACT_B): act_q[1] <= act_cfg_t'(wr_data[ACT_W-1:0]);
        AW'(ADDR_FRC):   frc_q    <= wr_data[2*NCH-1:0];
        default: ;
      endcase
    end
  end

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_fan
      assign shadow_en[g] = ctrl_q[g];
      assign ld_sel[g]    = ld_sel_e'(ctrl_q[2+2*g +: 2]);
      assign act_cfg[g]   = act_q[g];
      assign frc_code[g]  = frc_q[2*g +: 2];
    end
  endgenerate

endmodule

// File: rtl/aq_cmp_unit.sv
module aq_cmp_unit
  import pwm_aq_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [CW-1:0] wdata,
  input  logic          shadow_en,
  input  ld_sel_e       ld_sel,
  input  logic [CW-1:0] cnt_val,
  input  logic          cnt_zero,
  input  logic          cnt_prd,
  input  logic          cnt_adv,
  input  logic          cnt_up,
  output logic [CW-1:0] act_val,
  output logic          hit
);

  logic [CW-1:0] shd_q;
  logic          load_now;

  always_comb begin
    unique case (ld_sel)
      LD_ZERO: load_now = cnt_zero;
      LD_PRD:  load_now = cnt_prd;
      LD_BOTH: load_now = cnt_zero | cnt_prd;
      default: load_now = 1'b0;
    endcase
  end

  // A direct write updates the shadow copy too, so a later switch to
  // shadow mode never loads a stale value.
  always_ff @(posedge clk) begin
    if (rst) begin
      shd_q   <= '0;
      act_val <= '0;
    end else begin
      if (wr) shd_q <= wdata;
      if (wr && !shadow_en)
        act_val <= wdata;
      else if (shadow_en && load_now)
        act_val <= shd_q;
    end
  end

  assign hit = cnt_adv && cnt_up && (cnt_val == act_val);

endmodule

// File: rtl/aq_out_chan.sv
module aq_out_chan
  import pwm_aq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      ev_zro,
  input  logic      ev_ca,
  input  logic      ev_cb,
  input  act_cfg_t  cfg,
  input  logic [1:0] frc,
  output logic      q
);

  aq_act_e sel_act;
  logic    nxt;

  // Highest-priority event carrying a real action decides the tick.
  always_comb begin
    if (ev_cb && cfg.on_cb != ACT_NONE)       sel_act = cfg.on_cb;
    else if (ev_ca && cfg.on_ca != ACT_NONE)  sel_act = cfg.on_ca;
    else if (ev_zro)                          sel_act = cfg.on_zro;
    else                                      sel_act = ACT_NONE;
  end

  always_comb begin
    unique case (sel_act)
      ACT_LOW:  nxt = 1'b0;
      ACT_HIGH: nxt = 1'b1;
      ACT_TOG:  nxt = ~q;
      default:  nxt = q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                  q <= 1'b0;
    else if (frc == FRC_LOW)  q <= 1'b0;
    else if (frc == FRC_HIGH) q <= 1'b1;
    else                      q <= nxt;
  end

endmodule

// File: rtl/pwm_aq_stage.sv
module pwm_aq_stage
  import pwm_aq_pkg::*;
#(
  parameter int CW = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt_val,
  input  logic          cnt_zero,
  input  logic          cnt_prd,
  input  logic          cnt_adv,
  input  logic          cnt_up,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic          pwm_a,
  output logic          pwm_b
);

  logic [NCH-1:0]           cmp_wr;
  logic [NCH-1:0]           shadow_en;
  ld_sel_e [NCH-1:0]        ld_sel;
  act_cfg_t [NCH-1:0]       act_cfg;
  logic [NCH-1:0][1:0]      frc_code;
  logic [NCH-1:0][CW-1:0]   cmp_act;
  logic [NCH-1:0]           hit;
  logic [NCH-1:0]           outs;

  aq_cfg_regs #(.CW(CW), .AW(AW)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .cmp_wr    (cmp_wr),
    .shadow_en (shadow_en),
    .ld_sel    (ld_sel),
    .act_cfg   (act_cfg),
    .frc_code  (frc_code)
  );

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_cmp
      aq_cmp_unit #(.CW(CW)) u_cmp (
        .clk       (clk),
        .rst       (rst),
        .wr        (cmp_wr[g]),
        .wdata     (wr_data),
        .shadow_en (shadow_en[g]),
        .ld_sel    (ld_sel[g]),
        .cnt_val   (cnt_val),
        .cnt_zero  (cnt_zero),
        .cnt_prd   (cnt_prd),
        .cnt_adv   (cnt_adv),
        .cnt_up    (cnt_up),
        .act_val   (cmp_act[g]),
        .hit       (hit[g])
      );
    end

    for (g = 0; g < NCH; g++) begin : g_out
      aq_out_chan u_out (
        .clk    (clk),
        .rst    (rst),
        .ev_zro (cnt_zero),
        .ev_ca  (hit[0]),
        .ev_cb  (hit[1]),
        .cfg    (act_cfg[g]),
        .frc    (frc_code[g]),
        .q      (outs[g])
      );
    end
  endgenerate

  assign pwm_a = outs[0];
  assign pwm_b = outs[1];

endmodule

// File: rtl/pwm_aq_checker.sv
module pwm_aq_checker #(
  parameter int CW = 16,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [CW-1:0] wr_data,
  input logic          cnt_zero,
  input logic          shd_a,
  input logic [1:0]    ld_a,
  input logic [CW-1:0] act_a,
  input logic          hit_a,
  input logic          hit_b,
  input logic [1:0]    frc_a,
  input logic [1:0]    frc_b,
  input logic          pwm_a,
  input logic          pwm_b
);

  assert_direct_write_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == AW'(0) && !shd_a) |=> (act_a == $past(wr_data)));

  assert_frozen_shadow_R4: assert property (@(posedge clk) disable iff (rst)
    (shd_a && ld_a == 2'd3) |=> $stable(act_a));

  assert_force_high_R9: assert property (@(posedge clk) disable iff (rst)
    (frc_a == 2'd2) |=> pwm_a);

  assert_force_low_R9: assert property (@(posedge clk) disable iff (rst)
    (frc_b == 2'd1) |=> !pwm_b);

  assert_hold_between_events_R10: assert property (@(posedge clk) disable iff (rst)
    ((frc_a == 2'd0 || frc_a == 2'd3) && !cnt_zero && !hit_a && !hit_b)
      |=> $stable(pwm_a));

endmodule

bind pwm_aq_stage pwm_aq_checker #(.CW(CW), .AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .cnt_zero (cnt_zero),
  .shd_a    (shadow_en[0]),
  .ld_a     (ld_sel[0]),
  .act_a    (cmp_act[0]),
  .hit_a    (hit[0]),
  .hit_b    (hit[1]),
  .frc_a    (frc_code[0]),
  .frc_b    (frc_code[1]),
  .pwm_a    (pwm_a),
  .pwm_b    (pwm_b)
);

// File: tb/sim_pwm_aq_stage.sv
`timescale 1ns/1ps
module sim_pwm_aq_stage;

  localparam int CW = 16;
  localparam int AW = 3;
  localparam int P  = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW-1:0] cnt_val = '0;
  logic          cnt_zero = 1'b0, cnt_prd = 1'b0, cnt_adv = 1'b0, cnt_up = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic          pwm_a, pwm_b;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;
  int ha, hb, hx;

  always #2.5 clk = ~clk;

  pwm_aq_stage #(.CW(CW), .AW(AW)) u0 (
    .clk(clk), .rst(rst), .cnt_val(cnt_val), .cnt_zero(cnt_zero),
    .cnt_prd(cnt_prd), .cnt_adv(cnt_adv), .cnt_up(cnt_up),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  endtask

  task automatic wr(input int a, input int d);
    cnt_adv = 0; cnt_zero = 0; cnt_prd = 0;
    wr_en = 1; wr_addr = AW'(a); wr_data = CW'(d);
    cyc();
    wr_en = 0;
  endtask

  // Drive the up counter from count 'from' for 'len' ticks, counting high samples.
  task automatic run(input int from, input int len, output int na, output int nb);
    int c;
    c = from; na = 0; nb = 0;
    for (int i = 0; i < len; i++) begin
      cnt_val = CW'(c); cnt_zero = (c == 0); cnt_prd = (c == P); cnt_adv = 1;
      cyc();
      if (pwm_a) na++;
      if (pwm_b) nb++;
      c = (c == P) ? 0 : c + 1;
    end
    cnt_adv = 0; cnt_zero = 0; cnt_prd = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (3) cyc();
    rst = 0;
    cyc();
    chk("R1 pwm_a", pwm_a, 0);
    chk("R1 pwm_b", pwm_b, 0);
    run(0, P+1, ha, hb);
    chk("R1 idle a", ha, 0);
    chk("R1 idle b", hb, 0);

    // R2 map: A zero->high, ca->low; B zero->high, cb->low
    wr(3, 6);
    wr(4, 18);
    for (int n = 0; n <= P+1; n++) begin
      wr(0, n); wr(1, P+1-n);
      run(0, P+1, ha, hb);
      run(0, P+1, ha, hb);
      chk("R2 R11 duty a", ha, n);
      chk("R7 duty b", hb, P+1-n);
    end
    wr(3, 9); // inverted: zero->low, ca->high
    for (int n = 0; n <= P+1; n++) begin
      wr(0, n);
      run(0, P+1, ha, hb);
      run(0, P+1, ha, hb);
      chk("R6 R11 inverted a", ha, P+1-n);
    end
    wr(3, 6);

    // R5 direction and advance qualifiers
    wr(0, 3);
    cnt_up = 0;
    run(0, P+1, ha, hb);
    run(0, P+1, ha, hb);
    chk("R5 down no match", ha, P+1);
    cnt_up = 1;
    run(0, 1, ha, hb);
    cnt_val = 3; cnt_adv = 0;
    cyc(); cyc();
    chk("R5 hold no match", pwm_a, 1);
    run(3, 1, ha, hb);
    chk("R5 advance match", pwm_a, 0);

    // R3/R4 shadow loading, A at period strobe
    wr(0, 3);
    run(0, 3, ha, hb);
    wr(2, 5);
    wr(0, 5);
    run(3, 5, ha, hb);
    chk("R4 prd old value", ha, 0);
    run(0, P+1, ha, hb);
    chk("R4 prd new value", ha, 5);
    wr(2, 13); // frozen
    wr(0, 2);
    run(0, P+1, ha, hb);
    run(0, P+1, ha, hb);
    chk("R4 frozen", ha, 5);
    run(0, 3, ha, hb);
    wr(2, 1); // zero load
    wr(0, 6);
    run(3, 5, ha, hb);
    chk("R4 zero old value", ha, 2);
    run(0, P+1, ha, hb);
    chk("R4 zero new value", ha, 6);
    run(0, 3, ha, hb);
    wr(2, 9); // either strobe
    wr(0, 4);
    run(3, 5, ha, hb);
    chk("R4 either old value", ha, 3);
    run(0, P+1, ha, hb);
    chk("R4 either new value", ha, 4);
    wr(2, 0);
    wr(0, 5);
    run(0, P+1, ha, hb);
    chk("R3 direct again", ha, 5);

    // R9 force codes
    wr(1, 5);
    wr(5, 6); // A high, B low
    run(0, P+1, ha, hb);
    run(0, P+1, ha, hb);
    chk("R9 force high a", ha, P+1);
    chk("R9 force low b", hb, 0);
    wr(5, 3); // code 3 on A, 0 on B
    run(0, P+1, ha, hb);
    run(0, P+1, ha, hb);
    chk("R9 code3 no force a", ha, 5);
    chk("R9 code0 no force b", hb, 5);

    // R10 release holds until next event
    run(0, 2, ha, hb);
    wr(5, 1);
    cyc();
    chk("R9 forced low mid", pwm_a, 0);
    wr(5, 0);
    run(2, 3, ha, hb);
    chk("R10 held after release", ha, 0);
    run(5, 3, ha, hb);
    run(0, 1, hx, hb);
    chk("R10 resume at zero", pwm_a, 1);

    // R6 toggle on zero only
    wr(3, 3);
    run(0, P+1, ha, hb);
    run(0, P+1, hx, hb);
    chk("R6 toggle first", ha, 0);
    chk("R6 toggle second", hx, P+1);

    // R8 priority with all three events on count 0
    wr(0, 0); wr(1, 0);
    wr(3, 9);  run(0, 1, ha, hb);
    chk("R8 ca over zero", pwm_a, 1);
    wr(3, 26); run(0, 1, ha, hb);
    chk("R8 cb over ca", pwm_a, 0);
    wr(3, 9);  run(0, 1, ha, hb);
    chk("R8 ca high", pwm_a, 1);
    wr(3, 6);  run(0, 1, ha, hb);
    chk("R8 ca low over zero", pwm_a, 0);

    finish_run();
  end

endmodule